// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block selects, for every processor in a cluster, the most urgent interrupt among a configurable set of sources. Each processor supplies its own view of which sources are enabled and which are pending; the sources share one 8-bit priority each. A lower priority value is more urgent. For each processor the block reports the identifier of the winning source as the highest pending interrupt, and it drives an interrupt request line toward that processor.

Two thresholds are applied per processor. The priority mask decides whether the winner is reported at all; if it is not, the spurious identifier 1023 is reported instead. A second and stricter test against the processor's running priority (the priority of the interrupt it is already servicing, or 0x100 when it is idle) decides whether the request line is raised. A global enable and a per-processor interface enable can silence a processor entirely. The selection is computed combinationally from the current inputs and registered once per clock.

Top module: `irq_prio_arbiter`

## Requirements
- R1: When no source is a candidate for a processor, its reported identifier is 1023 and its request line is low.
- R2: A source is a candidate for processor c only when both its enable bit and its pending bit for c are set (bit c*NUM_SRC+s of each vector for source s); either bit alone has no effect on the outputs.
- R3: Among candidates, the one with the numerically lowest priority (bits s*8+7..s*8 of the priority vector) wins.
- R4: When candidates share the lowest priority, the one with the lowest identifier wins.
- R5: The winner is reported only if its priority is strictly below the processor's 8-bit priority mask; a priority equal to or above the mask reports 1023 with the request line low. A mask of 0 therefore blocks every source.
- R6: The request line is raised only if the reported winner's priority is also strictly below the processor's 9-bit running priority; a running priority of 0x100 means idle and lets any reported winner raise the line, and 0 never does.
- R7: If the global enable or the processor's interface enable is clear, that processor reports 1023 and its request line is low.
- R8: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge; during reset the identifiers are 1023 and the request lines low.
- R9: Each processor's outputs depend only on its own enable, pending, mask, running priority and interface enable inputs plus the shared priorities and global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Global forwarding enable |
| cpu_en_i | input | NUM_CPU | Per-processor interface enable |
| src_en_i | input | NUM_CPU*NUM_SRC | Per-processor source enables, bit c*NUM_SRC+s |
| src_pend_i | input | NUM_CPU*NUM_SRC | Per-processor pending bits, bit c*NUM_SRC+s |
| src_prio_i | input | NUM_SRC*8 | Priority of each source, 8 bits per source |
| prio_mask_i | input | NUM_CPU*8 | Per-processor priority mask |
| run_prio_i | input | NUM_CPU*9 | Per-processor running priority, 0x100 when idle |
| hp_id_o | output | NUM_CPU*10 | Per-processor highest pending identifier, 1023 if none |
| irq_o | output | NUM_CPU | Per-processor interrupt request |

## Verification
The bench targets ties on equal priority, where a design that resolved toward the higher identifier or kept the last match would report the wrong source, and priorities exactly equal to the mask or the running priority, where a non-strict comparison would report a masked source or raise a request that must stay low. It also drives enable-only and pending-only sources, which a design that ORed the two would wrongly select, and a source count that is not a power of two, where padding leaves of a reduction tree could leak a phantom winner. Idle running priority 0x100, zero masks, and one processor disabled while the other is active check that the thresholds and enables are applied per processor.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned PRIO_W  = 8;
  localparam int unsigned RUN_W   = PRIO_W + 1;
  localparam int unsigned ID_W    = 10;
  localparam logic [ID_W-1:0]  SPURIOUS_ID = '1;
  localparam logic [RUN_W-1:0] NO_PRIO     = RUN_W'(1) << PRIO_W;

  typedef struct packed {
    logic [RUN_W-1:0] prio;
    logic [ID_W-1:0]  id;
  } cand_t;
endpackage

// File: rtl/irq_arb_min_tree.sv
module irq_arb_min_tree
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0]        vld_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [RUN_W-1:0]          best_prio_o,
  output logic [ID_W-1:0]           best_id_o
);
  localparam int unsigned LVL    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
  localparam int unsigned LEAVES = 1 << LVL;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_SRC) begin : g_real
      assign node[LEAVES-1+k] = vld_i[k]
                              ? cand_t'{prio: {1'b0, prio_i[k*PRIO_W +: PRIO_W]}, id: ID_W'(k)}
                              : cand_t'{prio: NO_PRIO, id: SPURIOUS_ID};
    end else begin : g_pad
      assign node[LEAVES-1+k] = cand_t'{prio: NO_PRIO, id: SPURIOUS_ID};
    end
  end

  // left subtree always covers lower ids: right wins only on strictly lower value
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    assign node[i] = (node[2*i+2].prio < node[2*i+1].prio) ? node[2*i+2] : node[2*i+1];
  end

  assign best_prio_o = node[0].prio;
  assign best_id_o   = node[0].id;
endmodule

// File: rtl/irq_arb_cpu_gate.sv
module irq_arb_cpu_gate
  import irq_arb_pkg::*;
(
  input  logic              dist_en_i,
  input  logic              cpu_en_i,
  input  logic [RUN_W-1:0]  best_prio_i,
  input  logic [ID_W-1:0]   best_id_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [RUN_W-1:0]  run_prio_i,
  output logic [ID_W-1:0]   hp_id_o,
  output logic              irq_o
);
  logic pass_mask;
  logic pass_run;

  // sentinel 0x100 never passes an 8-bit mask, so no-candidate yields spurious
  assign pass_mask = best_prio_i < {1'b0, mask_i};
  assign pass_run  = best_prio_i < run_prio_i;

  always_comb begin
    hp_id_o = SPURIOUS_ID;
    irq_o   = 1'b0;
    if (dist_en_i && cpu_en_i && pass_mask) begin
      hp_id_o = best_id_i;
      irq_o   = pass_run;
    end
  end
endmodule

// File: rtl/irq_arb_out_reg.sv
module irq_arb_out_reg #(
  parameter int unsigned     W        = 1,
  parameter logic [W-1:0]    RST_VAL  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        dist_en_i,
  input  logic [NUM_CPU-1:0]          cpu_en_i,
  input  logic [NUM_CPU*NUM_SRC-1:0]  src_en_i,
  input  logic [NUM_CPU*NUM_SRC-1:0]  src_pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio_i,
  input  logic [NUM_CPU*PRIO_W-1:0]   prio_mask_i,
  input  logic [NUM_CPU*RUN_W-1:0]    run_prio_i,
  output logic [NUM_CPU*ID_W-1:0]     hp_id_o,
  output logic [NUM_CPU-1:0]          irq_o
);
  localparam int unsigned OUT_W = ID_W + 1;
  localparam logic [OUT_W-1:0] OUT_RST = {SPURIOUS_ID, 1'b0};

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] cand;
    logic [RUN_W-1:0]   best_prio;
    logic [ID_W-1:0]    best_id;
    logic [ID_W-1:0]    hp_id_d;
    logic               irq_d;
    logic [OUT_W-1:0]   out_q;

    assign cand = src_en_i[c*NUM_SRC +: NUM_SRC] & src_pend_i[c*NUM_SRC +: NUM_SRC];

    irq_arb_min_tree #(.NUM_SRC(NUM_SRC)) u_tree (
      .vld_i       (cand),
      .prio_i      (src_prio_i),
      .best_prio_o (best_prio),
      .best_id_o   (best_id)
    );

    irq_arb_cpu_gate u_gate (
      .dist_en_i   (dist_en_i),
      .cpu_en_i    (cpu_en_i[c]),
      .best_prio_i (best_prio),
      .best_id_i   (best_id),
      .mask_i      (prio_mask_i[c*PRIO_W +: PRIO_W]),
      .run_prio_i  (run_prio_i[c*RUN_W +: RUN_W]),
      .hp_id_o     (hp_id_d),
      .irq_o       (irq_d)
    );

    irq_arb_out_reg #(.W(OUT_W), .RST_VAL(OUT_RST)) u_oreg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({hp_id_d, irq_d}),
      .q_o    (out_q)
    );

    assign hp_id_o[c*ID_W +: ID_W] = out_q[OUT_W-1:1];
    assign irq_o[c]                = out_q[0];
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      dist_en_i,
  input logic [NUM_CPU-1:0]        cpu_en_i,
  input logic [NUM_CPU*PRIO_W-1:0] prio_mask_i,
  input logic [NUM_CPU*RUN_W-1:0]  run_prio_i,
  input logic [NUM_CPU*ID_W-1:0]   hp_id_o,
  input logic [NUM_CPU-1:0]        irq_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    // R1: a request always comes with a real identifier
    a_r1_irq_needs_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> hp_id_o[c*ID_W +: ID_W] != SPURIOUS_ID);
    // R2: reported identifiers are in range
    a_r2_id_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hp_id_o[c*ID_W +: ID_W] != SPURIOUS_ID |-> hp_id_o[c*ID_W +: ID_W] < ID_W'(NUM_SRC));
    // R5: zero mask blocks everything on the next cycle
    a_r5_zero_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio_mask_i[c*PRIO_W +: PRIO_W] == '0 |=> hp_id_o[c*ID_W +: ID_W] == SPURIOUS_ID && !irq_o[c]);
    // R6: running priority 0 never lets a request through
    a_r6_run_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_prio_i[c*RUN_W +: RUN_W] == '0 |=> !irq_o[c]);
    // R7: disabled processor is quiet on the next cycle
    a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dist_en_i && cpu_en_i[c]) |=> hp_id_o[c*ID_W +: ID_W] == SPURIOUS_ID && !irq_o[c]);
  end
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;
  localparam int NS = 6;
  localparam int NC = 2;
  localparam int SPUR = 1023;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              dist_en;
  logic [NC-1:0]     cpu_en;
  logic [NC*NS-1:0]  en, pend;
  logic [NS*8-1:0]   prio;
  logic [NC*8-1:0]   mask;
  logic [NC*9-1:0]   run;
  logic [NC*10-1:0]  hp_id;
  logic [NC-1:0]     irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(NS), .NUM_CPU(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
    .src_en_i(en), .src_pend_i(pend), .src_prio_i(prio), .prio_mask_i(mask),
    .run_prio_i(run), .hp_id_o(hp_id), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input int c, output int id, output int rq);
    int best = 256;
    id = SPUR;
    rq = 0;
    for (int s = 0; s < NS; s++)
      if (en[c*NS+s] && pend[c*NS+s] && int'(prio[s*8 +: 8]) < best) begin
        best = int'(prio[s*8 +: 8]);
        id = s;
      end
    if (!(dist_en && cpu_en[c]) || best >= int'(mask[c*8 +: 8])) begin
      id = SPUR;
    end else begin
      rq = (best < int'(run[c*9 +: 9])) ? 1 : 0;
    end
  endfunction

  int exp_id [NC];
  int exp_rq [NC];

  task automatic capture();
    for (int c = 0; c < NC; c++) model(c, exp_id[c], exp_rq[c]);
  endtask

  task automatic check_cpu(input int c, input string req);
    chk(req, int'(hp_id[c*10 +: 10]), exp_id[c]);
    chk(req, int'(irq[c]), exp_rq[c]);
  endtask

  // inputs set at negedge; step samples one clock later at negedge
  task automatic step(input string req);
    capture();
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) check_cpu(c, req);
  endtask

  task automatic idle_all();
    dist_en = 1'b1; cpu_en = '1; en = '0; pend = '0; prio = '1;
    mask = '1; run = {NC{9'h100}};
  endtask

  initial begin
    idle_all();
    en = '1; pend = '1; prio = '0;
    #11;
    chk("R8 reset id", int'(hp_id[9:0]), SPUR);
    chk("R8 reset irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_all();
    step("R1 no candidate");

    // R2: enable-only and pending-only sources are ignored
    en[0*NS+1] = 1'b1; pend[0*NS+2] = 1'b1; prio = '0;
    step("R2 half candidates");
    pend[0*NS+1] = 1'b1;
    step("R2 full candidate");

    // R3/R4: tie and ordering, R9 per-cpu vectors
    idle_all();
    prio = {8'd5, 8'd3, 8'd3, 8'd9, 8'd3, 8'd7};
    en = '1; pend = '1;
    pend[1*NS+1] = 1'b0;
    step("R4 tie lowest id");
    chk("R4 cpu0 id 1", int'(hp_id[9:0]), 1);
    chk("R9 cpu1 id 3", int'(hp_id[19:10]), 3);

    // R5: mask equal to winner priority blocks, one above passes
    mask[7:0] = 8'd3;
    step("R5 mask equal");
    mask[7:0] = 8'd4;
    step("R5 mask above");
    mask = '0;
    step("R5 zero mask");

    // R6: running priority thresholds
    mask = '1;
    run[8:0] = 9'd3;
    step("R6 run equal");
    run[8:0] = 9'd4;
    step("R6 run above");
    run[8:0] = 9'h100;
    prio[7:0] = 8'hFE; en = '0; pend = '0; en[0] = 1'b1; pend[0] = 1'b1;
    step("R6 idle run");
    prio[7:0] = 8'hFF;
    step("R5 prio ff never passes");

    // R7: enables
    idle_all();
    en = '1; pend = '1; prio = '0;
    dist_en = 1'b0;
    step("R7 global off");
    dist_en = 1'b1; cpu_en = 2'b10;
    step("R7 cpu0 off");

    // R8: outputs hold until the next edge
    cpu_en = 2'b11;
    step("R8 settle");
    prio = {8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0};
    en[0] = 1'b0;
    #1;
    for (int c = 0; c < NC; c++) check_cpu(c, "R8 held before edge");
    step("R8 after edge");

    // near-exhaustive sweep with ties and boundary values
    for (int it = 0; it < 4000; it++) begin
      dist_en = ($urandom_range(0, 15) != 0);
      cpu_en  = NC'($urandom_range(0, 3)) | ($urandom_range(0, 3) != 0 ? NC'('1) : NC'(0));
      en      = (NC*NS)'($urandom);
      pend    = (NC*NS)'($urandom);
      for (int s = 0; s < NS; s++)
        case ($urandom_range(0, 5))
          0: prio[s*8 +: 8] = 8'd0;
          1: prio[s*8 +: 8] = 8'd2;
          2: prio[s*8 +: 8] = 8'd3;
          3: prio[s*8 +: 8] = 8'h80;
          4: prio[s*8 +: 8] = 8'hFF;
          default: prio[s*8 +: 8] = 8'($urandom);
        endcase
      for (int c = 0; c < NC; c++) begin
        mask[c*8 +: 8] = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 4)) : 8'($urandom);
        case ($urandom_range(0, 3))
          0: run[c*9 +: 9] = 9'h100;
          1: run[c*9 +: 9] = 9'($urandom_range(0, 4));
          default: run[c*9 +: 9] = 9'($urandom_range(0, 255));
        endcase
      end
      step("R3 sweep");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule